// File: doc/BRIEF.md
# Lockable PWM Timer

A single-channel pulse-width modulator sits behind a plain 32-bit register bus. Software programs a period and a duty count, both in clock cycles. It also programs a control word. That word starts the channel and chooses the output level for the duty phase and the level the pin holds while the channel is stopped. A free-running counter steps through each period. The output shows the duty level for the first `duty` counts of each period and the opposite level for the rest, so the waveform is left-aligned.

New period, duty and polarity values are first written into staging registers. They reach the running waveform only at a period boundary, so a cycle is never cut short or stretched by a write. A lock bit in the control word holds every staged value back. Software can set the lock, rewrite the period, duty and polarity, and clear the lock. All three settings then take effect together at the next boundary.

Top module: `pwm_lock_timer`

## Requirements
- R1: After reset the output is 0 and the period, duty and control registers read back as 0.
- R2: A read asserted in one cycle returns its data on `rd_data` in the next cycle. The period (offset 0x4) and duty (offset 0x8) registers return the last value written to them. The control register (offset 0xC) returns the written value masked to bits 0, 1, 3, 4, 5, 6 and 8, which is mask 0x17B.
- R3: Offset 0x0 reads the running counter. The counter is 0 while the channel is stopped and stays below the active period while it runs. Writes to offset 0x0 have no effect.
- R4: The channel runs only when control bit 0 (enable) and control bit 1 (continuous) are both 1. Otherwise the output holds the idle level given by control bit 4 (1 = high).
- R5: While running with 0 < duty < period, the output repeats every `period` cycles. It is at the duty level for exactly `duty` of those cycles.
- R6: Control bit 3 sets the duty-phase level: 1 drives high during the duty phase and 0 drives low. The remaining cycles of the period take the opposite level.
- R7: A duty of 0 keeps the output at the non-duty level. A duty of at least the period keeps it at the duty level for the whole cycle.
- R8: An active period of 0 keeps the output at the idle level even while the channel is enabled.
- R9: With the lock clear, new period, duty and polarity values reach the waveform only at a period boundary, or while the channel is stopped, and never partway through a cycle.
- R10: While control bit 6 (lock) is 1, writes to period, duty and the polarity bits are stored and read back but do not change the running waveform.
- R11: Clearing the lock applies the staged period, duty and polarity together at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions check four properties on every cycle. The counter never reaches the active period. The stopped and zero-period output equals the active idle level. The active period and duty change only after a wrap or while the channel is stopped. Nothing changes while the lock is held. The bench scenarios cover what a single cycle cannot show: the duty fraction over a full period, the spacing of rising edges, the inverted duty phase, the duty clamps, and the readback values. They also show that a locked reconfiguration leaves the old waveform running until release, and that the new period and polarity then appear together.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;
  localparam int unsigned OFS_CNT  = 4'h0;
  localparam int unsigned OFS_PER  = 4'h4;
  localparam int unsigned OFS_DUTY = 4'h8;
  localparam int unsigned OFS_CTRL = 4'hC;

  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_CONT  = 1;
  localparam int unsigned B_DLVL  = 3;
  localparam int unsigned B_ILVL  = 4;
  localparam int unsigned B_ALIGN = 5;
  localparam int unsigned B_LOCK  = 6;
  localparam int unsigned B_LPWR  = 8;

  localparam logic [31:0] CTRL_MASK = 32'h0000_017B;
endpackage

// File: rtl/pwm_lock_regs.sv
module pwm_lock_regs
  import pwm_lock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] stg_period,
  output logic [DATA_W-1:0] stg_duty,
  output logic [DATA_W-1:0] ctrl_q
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(CTRL_MASK);

  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_period <= '0;
      stg_duty   <= '0;
      ctrl_q     <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(OFS_PER):  stg_period <= wr_data;
        ADDR_W'(OFS_DUTY): stg_duty   <= wr_data;
        ADDR_W'(OFS_CTRL): ctrl_q     <= wr_data & MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFS_CNT):  rd_mux = cnt;
      ADDR_W'(OFS_PER):  rd_mux = stg_period;
      ADDR_W'(OFS_DUTY): rd_mux = stg_duty;
      ADDR_W'(OFS_CTRL): rd_mux = ctrl_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  a_r2_ctrl_masked: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~MASK) == '0);
endmodule

// File: rtl/pwm_lock_core.sv
module pwm_lock_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              lock,
  input  logic [DATA_W-1:0] stg_period,
  input  logic [DATA_W-1:0] stg_duty,
  input  logic              stg_dlvl,
  input  logic              stg_ilvl,
  output logic [DATA_W-1:0] cnt,
  output logic              pwm_out
);
  logic [DATA_W-1:0] per_act, duty_act;
  logic              dlvl_act, ilvl_act;
  logic              wrap, upd;

  assign wrap = (per_act == '0) || (cnt >= per_act - DATA_W'(1));
  assign upd  = !lock && (!run || wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_act  <= '0;
      duty_act <= '0;
      dlvl_act <= 1'b0;
      ilvl_act <= 1'b0;
    end else if (upd) begin
      per_act  <= stg_period;
      duty_act <= stg_duty;
      dlvl_act <= stg_dlvl;
      ilvl_act <= stg_ilvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (!run || wrap) cnt <= '0;
    else                  cnt <= cnt + DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                        pwm_out <= 1'b0;
    else if (!run || per_act == '0) pwm_out <= ilvl_act;
    else if (cnt < duty_act)        pwm_out <= dlvl_act;
    else                            pwm_out <= !dlvl_act;
  end

  a_r3_cnt_below_period: assert property (@(posedge clk) disable iff (rst)
    (per_act != '0) |-> (cnt < per_act));

  a_r4_idle_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(run)) |-> (pwm_out == $past(ilvl_act)));

  a_r8_zero_period_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run) && $past(per_act) == '0) |-> (pwm_out == $past(ilvl_act)));

  a_r9_hold_midcycle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run) && !$past(wrap)) |->
      ($stable(per_act) && $stable(duty_act) && $stable(dlvl_act)));

  a_r10_hold_locked: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lock)) |->
      ($stable(per_act) && $stable(duty_act) && $stable(dlvl_act) && $stable(ilvl_act)));
endmodule

// File: rtl/pwm_lock_timer.sv
module pwm_lock_timer
  import pwm_lock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_out
);
  logic [DATA_W-1:0] cnt, stg_period, stg_duty, ctrl_q;
  logic              run;

  assign run = ctrl_q[B_EN] && ctrl_q[B_CONT];

  pwm_lock_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .cnt(cnt), .rd_data(rd_data),
    .stg_period(stg_period), .stg_duty(stg_duty), .ctrl_q(ctrl_q)
  );

  pwm_lock_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .run(run), .lock(ctrl_q[B_LOCK]),
    .stg_period(stg_period), .stg_duty(stg_duty),
    .stg_dlvl(ctrl_q[B_DLVL]), .stg_ilvl(ctrl_q[B_ILVL]),
    .cnt(cnt), .pwm_out(pwm_out)
  );
endmodule

// File: tb/pwm_lock_timer_tb.sv
module pwm_lock_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  pwm_lock_timer u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // number of high samples over n consecutive cycles
  task automatic high_count(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  // cycles between two consecutive rising edges
  task automatic rise_gap(output int g);
    logic prev;
    int t0;
    t0 = -1; g = 0; prev = pwm_out;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) begin
        if (t0 < 0) t0 = i;
        else begin g = i - t0; break; end
      end
      prev = pwm_out;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 out", pwm_out, 0);
    rd(4'h4, d); check("R1 period", d, 0);
    rd(4'hC, d); check("R1 ctrl", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(4'h4, 32'h1234_5678); rd(4'h4, d); check("R2 period", d, 32'h1234_5678);
    wr(4'h8, 32'hCAFE_0001); rd(4'h8, d); check("R2 duty", d, 32'hCAFE_0001);
    wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, d); check("R2 ctrl mask", d, 32'h17B);
    wr(4'hC, 32'h0);
  endtask

  task automatic t_counter();
    logic [31:0] d;
    wr(4'hC, 32'h0); idle(2);
    wr(4'h0, 32'h7); rd(4'h0, d); check("R3 write ignored", d, 0);
    wr(4'h4, 5); wr(4'h8, 2); wr(4'hC, 32'h0B); idle(3);
    for (int i = 0; i < 6; i++) begin
      rd(4'h0, d); check("R3 cnt<period", (d < 5) ? 1 : 0, 1);
    end
  endtask

  task automatic t_disabled();
    int h;
    wr(4'hC, 32'h19); idle(12); high_count(10, h); check("R4 en only idle1", h, 10);
    wr(4'hC, 32'h12); idle(12); high_count(10, h); check("R4 cont only idle1", h, 10);
    wr(4'hC, 32'h08); idle(12); high_count(10, h); check("R4 stopped idle0", h, 0);
  endtask

  task automatic t_basic();
    int h, g;
    wr(4'h4, 5); wr(4'h8, 2); wr(4'hC, 32'h0B); idle(12);
    high_count(5, h); check("R5 duty 2/5", h, 2);
    rise_gap(g); check("R5 period 5", g, 5);
    wr(4'h4, 7); wr(4'h8, 3); idle(20);
    high_count(7, h); check("R5 duty 3/7", h, 3);
    rise_gap(g); check("R5 period 7", g, 7);
  endtask

  task automatic t_invert();
    int h;
    wr(4'h4, 5); wr(4'h8, 2); wr(4'hC, 32'h03); idle(20);
    high_count(5, h); check("R6 duty low", h, 3);
  endtask

  task automatic t_clamps();
    int h;
    wr(4'hC, 32'h0B); wr(4'h8, 0); idle(20);
    high_count(10, h); check("R7 duty0", h, 0);
    wr(4'h8, 9); idle(20);
    high_count(10, h); check("R7 duty>=period", h, 10);
    wr(4'h8, 5); idle(20);
    high_count(10, h); check("R7 duty==period", h, 10);
  endtask

  task automatic t_zero_period();
    int h;
    wr(4'h8, 2); wr(4'h4, 0); wr(4'hC, 32'h1B); idle(20);
    high_count(10, h); check("R8 period0 idle1", h, 10);
    wr(4'hC, 32'h0B); idle(4);
    high_count(10, h); check("R8 period0 idle0", h, 0);
  endtask

  task automatic t_lock();
    int h, g;
    logic [31:0] d;
    wr(4'hC, 32'h0); wr(4'h4, 5); wr(4'h8, 2); wr(4'hC, 32'h0B); idle(12);
    // R9: unlocked mid-run update still yields a clean waveform
    wr(4'h8, 1); idle(15); high_count(5, h); check("R9 unlocked update", h, 1);
    wr(4'h8, 2); idle(15);
    wr(4'hC, 32'h4B);
    wr(4'h4, 8); wr(4'h8, 6); wr(4'hC, 32'h43);
    idle(20);
    high_count(5, h); check("R10 old duty kept", h, 2);
    rise_gap(g); check("R10 old period kept", g, 5);
    rd(4'h4, d); check("R10 staged period", d, 8);
    wr(4'hC, 32'h03); idle(20);
    high_count(8, h); check("R11 new period+polarity", h, 2);
    rise_gap(g); check("R11 new period", g, 8);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_readback();
    t_counter();
    t_disabled();
    t_basic();
    t_invert();
    t_clamps();
    t_zero_period();
    t_lock();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule